// File: doc/BRIEF.md
# SPI Byte Master for a Processor I/O Space

This block sits on the I/O bus of an 8-bit processor and turns single register writes into SPI mode 0 byte exchanges. Software writes a byte to the data register. The block lowers the chip select of the chosen device and clocks the byte out on MOSI, most significant bit first. At the same time it shifts in the byte coming back on MISO. That received byte can then be read from the same register address.

Chip select is not released when a byte finishes, so a command byte and any number of following data bytes share one select window. Software closes the window with a separate end command in the control register. A status read shows whether a byte is still moving, whether a select window is open, and which device is chosen. The SCLK rate comes from the bus clock through a programmable half-period count. The fastest setting gives one bus cycle per phase, which is a division by two.

Register map, addressed by `bus_addr`:
- 0 is data. A write starts a byte. A read returns the last completed received byte.
- 1 is control and status. On a write, bit 7 is the end command and bits 1:0 are the device index. On a read, bit 0 is busy, bit 1 is window open, and bits 3:2 are the device index.
- 2 is the half-period register, holding the number of bus cycles per SCLK phase minus one.
- 3 reads as zero.

Top module: `spi_byte_host`

## Requirements
- R1: After reset, every `cs_n` line is high, `sclk` is low, the status read is 0, the data read is 0, and the half-period register reads its reset value of 1.
- R2: A data write (address 0) while idle drives low the `cs_n` line of the selected device on the next cycle. SCLK stays low while all `cs_n` lines are high.
- R3: Each SCLK phase lasts (half-period register + 1) bus cycles. A byte gives exactly 8 rising SCLK edges. Status bit 0 reads 1 from the cycle after the data write for 16 × (half-period + 1) cycles, and clears on the eighth falling edge.
- R4: MOSI presents the written byte most significant bit first. It changes only while SCLK is low and holds steady through each high phase.
- R5: MISO is sampled at each rising SCLK edge, and the first sampled bit becomes bit 7. After completion, a read of address 0 returns the full received byte.
- R6: Chip select stays low after a byte completes and while busy, so several bytes chain under one select window (status bit 1 reads 1).
- R7: A data write while busy is ignored. The byte in flight and its edge count are unchanged, and no restart happens.
- R8: A control write with bit 7 set while idle and a window is open raises all `cs_n` after one half-period, with SCLK low. The same write while busy has no effect.
- R9: At most one `cs_n` line is low at a time. The device index written to control bits 1:0 takes effect only while idle with no window open, and reads back in status bits 3:2.
- R10: The half-period register (address 2) reads back its value. A write to it while busy is ignored.
- R11: Reads have no side effects. Repeated reads return the same value, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Peripheral selected for this bus cycle |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_DEV | Active-low device selects |

## Verification
The properties assume that a write lasts one cycle with `bus_sel` and `bus_wr` both high. They also assume that `miso` changes only away from rising SCLK edges, so that whatever is presented during the low phase is what gets captured. The bench drives bus strokes just after a clock edge and holds them for a single cycle. Its SPI device model updates `miso` only on falling SCLK. Random device choices, half-periods of 1 to 4 cycles and chain lengths of 1 to 3 bytes stay inside the legal register encodings. Deliberate writes during busy phases probe the ignore rules.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2,
        ENG_STOP = 2'd3
    } eng_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    localparam int CTRL_END_POS  = 7;
    localparam int STAT_BUSY_POS = 0;
    localparam int STAT_OPEN_POS = 1;
    localparam int STAT_DEV_LSB  = 2;

endpackage

// File: rtl/spi_half_tick.sv
// Phase timer: pulses tick at the end of each SCLK half-period while running.
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_state_t;

    tick_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        tick  = 1'b0;
        if (!run) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == half_m1) begin
            tick      = 1'b1;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/spi_shift_unit.sv
// Full-duplex shifter: MSB-first transmit, receive shifted in from the LSB side.
module spi_shift_unit #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_byte,
    input  logic            rise,
    input  logic            fall,
    input  logic            miso,
    output logic            mosi,
    output logic [BITS-1:0] rx_byte,
    output logic            last_bit
);

    localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;

    typedef struct packed {
        logic [BITS-1:0]  tx_sh;
        logic [BITS-1:0]  rx_sh;
        logic [CNT_W-1:0] bit_cnt;
    } shift_state_t;

    shift_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.tx_sh   = load_byte;
            nxt_d.rx_sh   = '0;
            nxt_d.bit_cnt = '0;
        end else begin
            if (rise) begin
                nxt_d.rx_sh = {cur_q.rx_sh[BITS-2:0], miso};
            end
            if (fall) begin
                nxt_d.tx_sh   = {cur_q.tx_sh[BITS-2:0], 1'b0};
                nxt_d.bit_cnt = cur_q.bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mosi     = cur_q.tx_sh[BITS-1];
    assign rx_byte  = cur_q.rx_sh;
    assign last_bit = (cur_q.bit_cnt == CNT_W'(BITS - 1));

endmodule

// File: rtl/spi_reg_file.sv
// Register decode, device and divider registers, and read mux.
module spi_reg_file
    import spi_host_pkg::*;
#(
    parameter int               DIV_W     = 8,
    parameter int               DEV_W     = 2,
    parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             busy,
    input  logic             win_open,
    input  logic [BUS_W-1:0] rx_byte,
    output logic             go_data,
    output logic             go_end,
    output logic [DIV_W-1:0] half_m1,
    output logic [DEV_W-1:0] dev_idx
);

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [DIV_W-1:0] div;
    } reg_state_t;

    localparam reg_state_t REG_RESET = '{dev: '0, div: DIV_RESET};

    reg_state_t cur_q, nxt_d;
    logic       wr_any;
    logic [BUS_W-1:0] status_w;

    assign wr_any = bus_sel && bus_wr;

    always_comb begin
        nxt_d   = cur_q;
        go_data = wr_any && (bus_addr == ADDR_DATA) && !busy;
        go_end  = wr_any && (bus_addr == ADDR_CTRL) && bus_wdata[CTRL_END_POS] && !busy;
        if (wr_any && (bus_addr == ADDR_CTRL) && !busy && !win_open) begin
            nxt_d.dev = bus_wdata[DEV_W-1:0];
        end
        if (wr_any && (bus_addr == ADDR_DIV) && !busy) begin
            nxt_d.div = bus_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        status_w                             = '0;
        status_w[STAT_BUSY_POS]              = busy;
        status_w[STAT_OPEN_POS]              = win_open;
        status_w[STAT_DEV_LSB +: DEV_W]      = cur_q.dev;
        case (bus_addr)
            ADDR_DATA: bus_rdata = rx_byte;
            ADDR_CTRL: bus_rdata = status_w;
            ADDR_DIV:  bus_rdata = BUS_W'(cur_q.div);
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= REG_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign half_m1 = cur_q.div;
    assign dev_idx = cur_q.dev;

endmodule

// File: rtl/spi_byte_host.sv
// Bus-mapped SPI mode 0 byte master with chained chip select.
module spi_byte_host
    import spi_host_pkg::*;
#(
    parameter int               NUM_DEV   = 4,
    parameter int               DIV_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_DEV-1:0] cs_n
);

    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    typedef struct packed {
        eng_state_e         state;
        logic               open;
        logic               sclk;
        logic [NUM_DEV-1:0] cs_n;
        logic [BUS_W-1:0]   rx_hold;
    } eng_t;

    localparam eng_t ENG_RESET = '{state: ENG_IDLE, open: 1'b0, sclk: 1'b0,
                                   cs_n: '1, rx_hold: '0};

    eng_t cur_q, nxt_d;

    logic               busy_w;
    logic               go_data;
    logic               go_end;
    logic [DIV_W-1:0]   half_m1;
    logic [DEV_W-1:0]   dev_idx;
    logic               tick;
    logic               sh_load;
    logic               sh_rise;
    logic               sh_fall;
    logic [BUS_W-1:0]   rx_byte;
    logic               last_bit;
    logic [NUM_DEV-1:0] dev_onehot;

    assign busy_w     = (cur_q.state != ENG_IDLE);
    assign dev_onehot = NUM_DEV'(1) << dev_idx;

    spi_reg_file #(
        .DIV_W     (DIV_W),
        .DEV_W     (DEV_W),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy_w),
        .win_open  (cur_q.open),
        .rx_byte   (cur_q.rx_hold),
        .go_data   (go_data),
        .go_end    (go_end),
        .half_m1   (half_m1),
        .dev_idx   (dev_idx)
    );

    spi_half_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_w),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    spi_shift_unit #(
        .BITS (BUS_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_byte (bus_wdata),
        .rise      (sh_rise),
        .fall      (sh_fall),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .last_bit  (last_bit)
    );

    always_comb begin
        nxt_d   = cur_q;
        sh_load = 1'b0;
        sh_rise = 1'b0;
        sh_fall = 1'b0;
        case (cur_q.state)
            ENG_IDLE: begin
                if (go_data) begin
                    nxt_d.state = ENG_LOW;
                    nxt_d.open  = 1'b1;
                    nxt_d.cs_n  = ~dev_onehot;
                    sh_load     = 1'b1;
                end else if (go_end && cur_q.open) begin
                    nxt_d.state = ENG_STOP;
                end
            end
            ENG_LOW: begin
                if (tick) begin
                    nxt_d.state = ENG_HIGH;
                    nxt_d.sclk  = 1'b1;
                    sh_rise     = 1'b1;
                end
            end
            ENG_HIGH: begin
                if (tick) begin
                    nxt_d.sclk = 1'b0;
                    sh_fall    = 1'b1;
                    if (last_bit) begin
                        nxt_d.state   = ENG_IDLE;
                        nxt_d.rx_hold = rx_byte;
                    end else begin
                        nxt_d.state = ENG_LOW;
                    end
                end
            end
            ENG_STOP: begin
                if (tick) begin
                    nxt_d.state = ENG_IDLE;
                    nxt_d.open  = 1'b0;
                    nxt_d.cs_n  = '1;
                end
            end
            default: nxt_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= ENG_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sclk = cur_q.sclk;
    assign cs_n = cur_q.cs_n;

endmodule

// File: rtl/spi_byte_host_chk.sv
module spi_byte_host_chk #(
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [7:0]         bus_wdata,
    input logic               sclk,
    input logic               mosi,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               busy
);

    logic wr_data;
    logic wr_end;

    assign wr_data = bus_sel && bus_wr && (bus_addr == 2'd0);
    assign wr_end  = bus_sel && bus_wr && (bus_addr == 2'd1) && bus_wdata[7];

    p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_sclk_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    p_mosi_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> (mosi == $past(mosi)));

    p_busy_holds_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(&cs_n));

    p_write_busy_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && wr_data) |=> busy);

    p_end_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && wr_end) |=> !(&cs_n));

    p_cs_rise_clock_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> (!sclk && !$past(sclk)));

endmodule

bind spi_byte_host spi_byte_host_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .busy      (busy_w)
);

// File: tb/spi_byte_host_tb.sv
module spi_byte_host_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [1:0]      bus_addr = 2'd0;
    logic [7:0]      bus_wdata = 8'd0;
    logic [7:0]      bus_rdata;
    logic            sclk;
    logic            mosi;
    logic            miso;
    logic [NDEV-1:0] cs_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] slave_sh = 8'd0;
    logic [7:0] mosi_cap = 8'd0;
    int rise_cnt = 0;
    int last_fall = 0;
    int cs_rise_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    spi_byte_host u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    // device model: presents MSB first, advances on falling SCLK
    assign miso = slave_sh[7];
    always @(posedge sclk) begin
        mosi_cap = {mosi_cap[6:0], mosi};
        rise_cnt++;
    end
    always @(negedge sclk) begin
        slave_sh  = {slave_sh[6:0], 1'b0};
        last_fall = cyc;
    end
    always @(posedge (&cs_n)) cs_rise_cyc = cyc;

    function automatic logic [NDEV-1:0] exp_cs(input int dev);
        return ~(NDEV'(1) << dev);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // one byte in an open or new window; checks timing, data both ways
    task automatic run_byte(input logic [7:0] tx, input logic [7:0] sl,
                            input int dev, input int h);
        logic [7:0] st;
        logic [7:0] rd;
        int busy_cnt = 0;
        slave_sh = sl; mosi_cap = 8'd0; rise_cnt = 0;
        bus_write(2'd0, tx);
        bus_read(2'd1, st);
        chk(cs_n == exp_cs(dev), "R2 cs low for selected device", int'(cs_n), int'(exp_cs(dev)));
        while (st[0] && busy_cnt < 2000) begin
            busy_cnt++;
            bus_read(2'd1, st);
        end
        chk(busy_cnt == 16*h, "R3 busy duration", busy_cnt, 16*h);
        chk(rise_cnt == 8, "R3 rising edges per byte", rise_cnt, 8);
        chk(mosi_cap == tx, "R4 mosi byte", int'(mosi_cap), int'(tx));
        bus_read(2'd0, rd);
        chk(rd == sl, "R5 received byte", int'(rd), int'(sl));
        chk(st[1] == 1'b1 && cs_n == exp_cs(dev), "R6 window stays open",
            int'(cs_n), int'(exp_cs(dev)));
    endtask

    task automatic end_txn(input int h);
        logic [7:0] st;
        int guard = 0;
        bus_write(2'd1, 8'h80);
        bus_read(2'd1, st);
        while (st[1] && guard < 200) begin
            guard++;
            bus_read(2'd1, st);
        end
        chk(cs_n == '1, "R8 cs released", int'(cs_n), 15);
        chk(cs_rise_cyc - last_fall >= h, "R8 release gap", cs_rise_cyc - last_fall, h);
    endtask

    task automatic setup(input int dev, input int h);
        logic [7:0] st;
        bus_write(2'd1, 8'(dev));
        bus_write(2'd2, 8'(h - 1));
        bus_read(2'd1, st);
        chk(st[3:2] == 2'(dev), "R9 device index readback", int'(st[3:2]), dev);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] v2;
        logic [7:0] st;
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 reset state
        @(negedge clk);
        chk(cs_n == '1, "R1 cs idle high", int'(cs_n), 15);
        chk(sclk == 1'b0, "R1 sclk idle low", int'(sclk), 0);
        bus_read(2'd1, v);
        chk(v == 8'h00, "R1 status after reset", int'(v), 0);
        bus_read(2'd0, v);
        chk(v == 8'h00, "R1 data after reset", int'(v), 0);
        bus_read(2'd2, v);
        chk(v == 8'h01, "R1 R10 divider reset", int'(v), 1);

        // R11 side-effect-free reads
        bus_read(2'd3, v);
        chk(v == 8'h00, "R11 unused address", int'(v), 0);

        // directed: fastest clock, device 2
        setup(2, 1);
        run_byte(8'hA5, 8'h3C, 2, 1);
        bus_read(2'd0, v); bus_read(2'd0, v2);
        chk(v == v2 && v == 8'h3C, "R11 repeated read stable", int'(v2), 60);
        end_txn(1);

        // directed: chained bytes on device 1, half-period 2
        setup(1, 2);
        run_byte(8'h01, 8'hC3, 1, 2);
        // R9: device change while window open is ignored
        bus_write(2'd1, 8'h03);
        bus_read(2'd1, st);
        chk(st[3:2] == 2'd1, "R9 device locked while open", int'(st[3:2]), 1);
        run_byte(8'h80, 8'h7E, 1, 2);
        run_byte(8'hFF, 8'h00, 1, 2);
        end_txn(2);

        // directed: writes during busy are ignored (R7, R8, R9, R10)
        setup(3, 3);
        slave_sh = 8'h96; mosi_cap = 8'd0; rise_cnt = 0;
        bus_write(2'd0, 8'h81);
        repeat (5) @(negedge clk);
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'h80);
        bus_write(2'd2, 8'h07);
        bus_read(2'd1, st);
        while (st[0]) bus_read(2'd1, st);
        chk(mosi_cap == 8'h81, "R7 byte unchanged by busy write", int'(mosi_cap), 129);
        chk(rise_cnt == 8, "R7 no restart", rise_cnt, 8);
        bus_read(2'd0, v);
        chk(v == 8'h96, "R7 received byte intact", int'(v), 150);
        chk(cs_n == exp_cs(3), "R8 end while busy ignored", int'(cs_n), int'(exp_cs(3)));
        chk(st[3:2] == 2'd3, "R9 device unchanged by busy write", int'(st[3:2]), 3);
        bus_read(2'd2, v);
        chk(v == 8'h02, "R10 divider write while busy ignored", int'(v), 2);
        end_txn(3);

        // random transactions
        for (int it = 0; it < 14; it++) begin
            int dev;
            int h;
            int nb;
            dev = int'($urandom % NDEV);
            h   = int'($urandom % 4) + 1;
            nb  = int'($urandom % 3) + 1;
            setup(dev, h);
            bus_read(2'd2, v);
            chk(v == 8'(h - 1), "R10 divider readback", int'(v), h - 1);
            for (int b = 0; b < nb; b++) begin
                run_byte(8'($urandom), 8'($urandom), dev, h);
            end
            end_txn(h);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule